// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host bridge. Software reaches it one dword at a time. Each access carries a function number, a dword index (byte offset divided by four), a 4-bit byte-lane mask and write data. Reads return registered data one cycle after the read strobe.

Two words at the bottom of the dword array are fixed identification constants. The words from 0x10 to 0x4C are reserved and read as zero. Two scratch-style words sit at 0x04 and 0x0C. A block of 44 writable dwords covers byte offsets 0x50 to 0xFC.

Two words in that block, at 0x58 and 0x5C, hold the attributes of thirteen shadow memory segments. A neighbouring decoder uses those attributes. When a write reaches one of these nibbles, the block pulses that segment's update strobe. The decoder then reads the segment's 2-bit attribute, which is already current in the same cycle.

Top module: `hb_cfg_regs`

## Requirements
- R1: After reset, rd_valid and every seg_upd bit are 0, and all seg_attr fields are 0. The array words reset as follows: index 0 (0x50) = 0x14020000, index 1 = 0x01520000, index 4 = 0x02020202, index 5 = 0x00000002, and every other index = 0. The words at 0x04 and 0x0C also reset to 0.
- R2: A read strobe in one cycle gives rd_valid = 1 in the next cycle, with rd_data holding the addressed word. rd_valid is 0 in any cycle that does not follow a read strobe.
- R3: An access whose function number is not 0 reads as zero. As a write, it changes no register and raises no strobe.
- R4: Dword index 0 (offset 0x00) always reads 0x71008086, and writes to it are ignored.
- R5: Dword index 2 (offset 0x08) always reads 0x06000001, and writes to it are ignored.
- R6: Offsets 0x10 to 0x4C (dword indices 4 to 19) read as zero, and writes to them are discarded.
- R7: Offsets 0x04 and 0x0C are each a 32-bit read/write register. A write updates only the byte lanes whose mask bit is set; mask bit k covers data bits 8k+7 down to 8k.
- R8: Offsets 0x50 to 0xFC form a 44-word array at index (offset − 0x50)/4. Writes merge into it under the byte mask, and every word reads back what was merged.
- R9: A write with function 0 to offset 0x58 or 0x5C pulses seg_upd for one cycle, in the cycle after the write, for each segment whose nibble lies in an enabled byte lane. The segment-to-nibble mapping is: segments 0 to 4 use nibbles 3 to 7 of 0x58, and segments 5 to 12 use nibbles 0 to 7 of 0x5C. A nibble n belongs to byte lane n/2.
- R10: Segment s's attribute appears on seg_attr[2s+1:2s] and equals the two low bits of its nibble. It changes only in a cycle where seg_upd[s] is 1.
- R11: A read and a write to the same register in one cycle return the value held before the write.
- R12: Writes to array words other than 0x58 and 0x5C never raise seg_upd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_func | input | 3 | Function number of the access |
| cfg_dw | input | 6 | Dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after cfg_rd |
| rd_data | output | 32 | Registered read data |
| seg_upd | output | 13 | One-cycle update strobe per shadow segment |
| seg_attr | output | 26 | 2-bit attribute per shadow segment |

## Verification
A corrupted array word shows up at rd_data on the first read of that offset, one cycle after the strobe. If that word is 0x58 or 0x5C, the fault also appears at once on seg_attr without any read. A wrong decode shows up in the cycle after the faulty write, in any of three ways: a missed or extra seg_upd bit, a reserved or constant word that no longer reads its fixed value, or a foreign-function write that leaves a trace. The bench therefore reads back every word it touches, and it checks seg_upd in the cycle after each write and again one cycle later.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;
    localparam int DW_IDX_W  = 6;
    localparam int ARR_BASE  = 20;                    // 0x50 / 4
    localparam int ARR_WORDS = (1 << DW_IDX_W) - ARR_BASE;
    localparam int SEG_NUM   = 13;
    localparam int ATTR_W    = 2;
    localparam int SEG_A_IDX = 2;                     // array index of 0x58
    localparam int SEG_B_IDX = 3;                     // array index of 0x5C
    localparam int SEG_A_CNT = 5;                     // segments held in 0x58
    localparam int SEG_A_NIB = 3;                     // first nibble used in 0x58

    typedef enum logic [2:0] {
        RG_ID,
        RG_CLASS,
        RG_CMD,
        RG_MISC,
        RG_RSVD,
        RG_ARR
    } rg_kind_e;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input logic [LANES-1:0]  be
    );
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int k = 0; k < LANES; k++)
            if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] arr_reset_val(input int idx);
        case (idx)
            0:       return 32'h1402_0000;
            1:       return 32'h0152_0000;
            4:       return 32'h0202_0202;
            5:       return 32'h0000_0002;
            default: return '0;
        endcase
    endfunction

    function automatic int seg_word(input int s);
        return (s < SEG_A_CNT) ? SEG_A_IDX : SEG_B_IDX;
    endfunction

    function automatic int seg_nibble(input int s);
        return (s < SEG_A_CNT) ? (s + SEG_A_NIB) : (s - SEG_A_CNT);
    endfunction

endpackage

// File: rtl/hb_cfg_decode.sv
module hb_cfg_decode
    import hb_cfg_pkg::*;
(
    input  logic [DW_IDX_W-1:0] dw,
    output rg_kind_e            kind,
    output logic [DW_IDX_W-1:0] arr_idx
);
    localparam logic [DW_IDX_W-1:0] DW_ID    = DW_IDX_W'(0);
    localparam logic [DW_IDX_W-1:0] DW_CMD   = DW_IDX_W'(1);
    localparam logic [DW_IDX_W-1:0] DW_CLASS = DW_IDX_W'(2);
    localparam logic [DW_IDX_W-1:0] DW_MISC  = DW_IDX_W'(3);
    localparam logic [DW_IDX_W-1:0] DW_ARR   = DW_IDX_W'(ARR_BASE);

    always_comb begin
        arr_idx = dw - DW_ARR;
        if (dw == DW_ID)          kind = RG_ID;
        else if (dw == DW_CMD)    kind = RG_CMD;
        else if (dw == DW_CLASS)  kind = RG_CLASS;
        else if (dw == DW_MISC)   kind = RG_MISC;
        else if (dw >= DW_ARR)    kind = RG_ARR;
        else                      kind = RG_RSVD;
    end
endmodule

// File: rtl/hb_cfg_array.sv
module hb_cfg_array
    import hb_cfg_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [DW_IDX_W-1:0]                  idx,
    input  logic [LANES-1:0]                     be,
    input  logic [WORD_W-1:0]                    wdata,
    output logic [ARR_WORDS-1:0][WORD_W-1:0]     words
);
    logic [ARR_WORDS-1:0][WORD_W-1:0] words_d, words_q;

    for (genvar i = 0; i < ARR_WORDS; i++) begin : g_word
        always_comb begin
            words_d[i] = words_q[i];
            if (we && (idx == DW_IDX_W'(i)))
                words_d[i] = lane_merge(words_q[i], wdata, be);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) words_q[i] <= arr_reset_val(i);
            else        words_q[i] <= words_d[i];
        end
    end

    assign words = words_q;

    AST_ARR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(words_q)) else $error("array changed without write"); // R6
endmodule

// File: rtl/hb_cfg_shadow.sv
module hb_cfg_shadow
    import hb_cfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit_a,
    input  logic                     hit_b,
    input  logic [LANES-1:0]         be,
    input  logic [WORD_W-1:0]        word_a,
    input  logic [WORD_W-1:0]        word_b,
    output logic [SEG_NUM-1:0]       seg_upd,
    output logic [SEG_NUM*ATTR_W-1:0] seg_attr
);
    logic [SEG_NUM-1:0] upd_d, upd_q;

    for (genvar s = 0; s < SEG_NUM; s++) begin : g_seg
        localparam int NIB  = seg_nibble(s);
        localparam int LANE = NIB / 2;
        if (seg_word(s) == SEG_A_IDX) begin : g_a
            always_comb upd_d[s] = hit_a && be[LANE];
            assign seg_attr[ATTR_W*s +: ATTR_W] = word_a[4*NIB +: ATTR_W];
        end else begin : g_b
            always_comb upd_d[s] = hit_b && be[LANE];
            assign seg_attr[ATTR_W*s +: ATTR_W] = word_b[4*NIB +: ATTR_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= '0;
        else        upd_q <= upd_d;
    end

    assign seg_upd = upd_q;

    AST_UPD_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_q) |-> $past(hit_a || hit_b)) else $error("strobe without shadow write"); // R12
    AST_UPD_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_q) |-> $past(|be)) else $error("strobe with no lane enabled"); // R9
endmodule

// File: rtl/hb_cfg_regs.sv
module hb_cfg_regs
    import hb_cfg_pkg::*;
#(
    parameter logic [31:0] ID_WORD    = 32'h7100_8086,
    parameter logic [31:0] CLASS_WORD = 32'h0600_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_rd,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_func,
    input  logic [5:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic [12:0] seg_upd,
    output logic [25:0] seg_attr
);
    typedef struct packed {
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] misc;
    } st_t;

    st_t st_d, st_q;

    rg_kind_e                         kind;
    logic [DW_IDX_W-1:0]              arr_idx;
    logic [ARR_WORDS-1:0][WORD_W-1:0] arr_words;
    logic                             func_ok;
    logic                             wr_ok;
    logic                             arr_we;
    logic                             hit_a;
    logic                             hit_b;

    assign func_ok = (cfg_func == 3'd0);
    assign wr_ok   = cfg_wr && func_ok;
    assign arr_we  = wr_ok && (kind == RG_ARR);
    assign hit_a   = arr_we && (arr_idx == DW_IDX_W'(SEG_A_IDX));
    assign hit_b   = arr_we && (arr_idx == DW_IDX_W'(SEG_B_IDX));

    hb_cfg_decode u_dec (
        .dw      (cfg_dw),
        .kind    (kind),
        .arr_idx (arr_idx)
    );

    hb_cfg_array u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .idx   (arr_idx),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .words (arr_words)
    );

    hb_cfg_shadow u_shd (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .be       (cfg_be),
        .word_a   (arr_words[SEG_A_IDX]),
        .word_b   (arr_words[SEG_B_IDX]),
        .seg_upd  (seg_upd),
        .seg_attr (seg_attr)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = cfg_rd;
        if (cfg_rd) begin
            st_d.rd_data = '0;
            if (func_ok) begin
                case (kind)
                    RG_ID:    st_d.rd_data = ID_WORD;
                    RG_CLASS: st_d.rd_data = CLASS_WORD;
                    RG_CMD:   st_d.rd_data = st_q.cmd;
                    RG_MISC:  st_d.rd_data = st_q.misc;
                    RG_ARR:   st_d.rd_data = arr_words[arr_idx];
                    default:  st_d.rd_data = '0;
                endcase
            end
        end
        if (wr_ok && kind == RG_CMD)  st_d.cmd  = lane_merge(st_q.cmd,  cfg_wdata, cfg_be);
        if (wr_ok && kind == RG_MISC) st_d.misc = lane_merge(st_q.misc, cfg_wdata, cfg_be);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

    AST_FOREIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !func_ok) |=> (rd_data == '0)) else $error("foreign read nonzero"); // R3
    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && func_ok && kind == RG_ID) |=> (rd_data == ID_WORD)) else $error("id word wrong"); // R4
    AST_CLASS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && func_ok && kind == RG_CLASS) |=> (rd_data == CLASS_WORD)) else $error("class word wrong"); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && func_ok && kind == RG_RSVD) |=> (rd_data == '0)) else $error("reserved nonzero"); // R6
    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_upd == '0) |-> $stable(seg_attr)) else $error("attr moved without strobe"); // R10
endmodule

// File: tb/hb_cfg_regs_test.sv
module hb_cfg_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [12:0] seg_upd;
    logic [25:0] seg_attr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_arr [44];
    logic [31:0] m_cmd;
    logic [31:0] m_misc;

    always #2 clk = ~clk;   // 250 MHz

    hb_cfg_regs uut (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_func(cfg_func), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .seg_upd(seg_upd), .seg_attr(seg_attr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
        return r;
    endfunction

    // segment map per R9: seg 0..4 -> 0x58 nibbles 3..7, seg 5..12 -> 0x5C nibbles 0..7
    function automatic int s_word(input int s); return (s < 5) ? 2 : 3; endfunction
    function automatic int s_nib(input int s);  return (s < 5) ? s + 3 : s - 5; endfunction

    function automatic logic [25:0] exp_attr();
        logic [25:0] a;
        for (int s = 0; s < 13; s++) a[2*s +: 2] = m_arr[s_word(s)][4*s_nib(s) +: 2];
        return a;
    endfunction

    function automatic logic [12:0] exp_upd(input int dw, input logic [3:0] be);
        logic [12:0] u = '0;
        for (int s = 0; s < 13; s++)
            if (dw == 20 + s_word(s) && be[s_nib(s) / 2]) u[s] = 1'b1;
        return u;
    endfunction

    // all tasks start and end on a falling edge
    task automatic wr(input logic [2:0] f, input int dw, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_func = f; cfg_dw = 6'(dw); cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (f == 3'd0) begin
            if (dw == 1) m_cmd = merge(m_cmd, d, be);
            if (dw == 3) m_misc = merge(m_misc, d, be);
            if (dw >= 20) m_arr[dw-20] = merge(m_arr[dw-20], d, be);
        end
    endtask

    task automatic rd(input string req, input logic [2:0] f, input int dw, input logic [31:0] exp);
        cfg_rd = 1'b1; cfg_func = f; cfg_dw = 6'(dw);
        @(negedge clk);
        cfg_rd = 1'b0;
        chk({req, " valid"}, 32'(rd_valid), 32'd1);
        chk(req, rd_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 seg_upd", 32'(seg_upd), 0);
        chk("R1 seg_attr", 32'(seg_attr), 0);
        for (int i = 0; i < 44; i++) rd("R1 array", 3'd0, 20 + i, m_arr[i]);
        rd("R1 cmd", 3'd0, 1, 32'd0);
        rd("R1 misc", 3'd0, 3, 32'd0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        chk("R2 idle no valid", 32'(rd_valid), 0);
        rd("R2 data", 3'd0, 21, 32'h0152_0000);
        @(negedge clk);
        chk("R2 valid drops", 32'(rd_valid), 0);
    endtask

    task automatic t_consts();
        wr(3'd0, 0, 4'hF, 32'hDEAD_BEEF);
        rd("R4 id", 3'd0, 0, 32'h7100_8086);
        wr(3'd0, 2, 4'hF, 32'h1234_5678);
        rd("R5 class", 3'd0, 2, 32'h0600_0001);
    endtask

    task automatic t_reserved();
        for (int dw = 4; dw < 20; dw += 5) begin
            wr(3'd0, dw, 4'hF, 32'hA5A5_A5A5);
            rd("R6 reserved", 3'd0, dw, 32'd0);
        end
        rd("R6 cmd unaffected", 3'd0, 1, m_cmd);
    endtask

    task automatic t_foreign();
        wr(3'd1, 24, 4'hF, 32'hFFFF_FFFF);
        rd("R3 array untouched", 3'd0, 24, m_arr[4]);
        wr(3'd5, 23, 4'hF, 32'hFFFF_FFFF);
        chk("R3 no strobe", 32'(seg_upd), 0);
        chk("R3 attr untouched", 32'(seg_attr), 32'(exp_attr()));
        wr(3'd2, 1, 4'hF, 32'hFFFF_FFFF);
        rd("R3 foreign id read", 3'd3, 0, 32'd0);
        rd("R3 foreign array read", 3'd7, 20, 32'd0);
        rd("R3 cmd untouched", 3'd0, 1, m_cmd);
    endtask

    task automatic t_cmd_misc();
        wr(3'd0, 1, 4'b0101, 32'h1122_3344);
        rd("R7 cmd lanes", 3'd0, 1, 32'h0022_0044);
        wr(3'd0, 3, 4'b1000, 32'hAB00_0000);
        wr(3'd0, 3, 4'b0011, 32'hFFFF_5566);
        rd("R7 misc lanes", 3'd0, 3, 32'hAB00_5566);
    endtask

    task automatic t_array();
        wr(3'd0, 20, 4'b0010, 32'hFFFF_77FF);
        rd("R8 word0 merge", 3'd0, 20, 32'h1402_7700);
        wr(3'd0, 63, 4'hF, 32'hCAFE_F00D);
        wr(3'd0, 62, 4'b1100, 32'h9876_5432);
        rd("R8 top word", 3'd0, 63, 32'hCAFE_F00D);
        rd("R8 word 0xF8", 3'd0, 62, 32'h9876_0000);
        chk("R12 no strobe", 32'(seg_upd), 0);
        wr(3'd0, 24, 4'b0001, 32'h0000_00EE);
        rd("R8 word4 merge", 3'd0, 24, 32'h0202_02EE);
    endtask

    task automatic t_shadow(input int dw, input logic [3:0] be, input logic [31:0] d);
        logic [12:0] eu;
        eu = exp_upd(dw, be);
        wr(3'd0, dw, be, d);
        chk("R9 strobe", 32'(seg_upd), 32'(eu));
        chk("R10 attr", 32'(seg_attr), 32'(exp_attr()));
        @(negedge clk);
        chk("R9 strobe single", 32'(seg_upd), 0);
        chk("R10 attr hold", 32'(seg_attr), 32'(exp_attr()));
    endtask

    task automatic t_same_cycle();
        cfg_rd = 1'b1; cfg_wr = 1'b1; cfg_func = 3'd0; cfg_dw = 6'd25;
        cfg_be = 4'hF; cfg_wdata = 32'h5555_AAAA;
        @(negedge clk);
        cfg_rd = 1'b0; cfg_wr = 1'b0;
        chk("R11 old value", rd_data, m_arr[5]);
        m_arr[5] = 32'h5555_AAAA;
        rd("R11 new value", 3'd0, 25, 32'h5555_AAAA);
    endtask

    initial begin
        for (int i = 0; i < 44; i++) m_arr[i] = '0;
        m_arr[0] = 32'h1402_0000; m_arr[1] = 32'h0152_0000;
        m_arr[4] = 32'h0202_0202; m_arr[5] = 32'h0000_0002;
        m_cmd = '0; m_misc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_consts();
        t_reserved();
        t_foreign();
        t_cmd_misc();
        t_array();
        t_shadow(22, 4'b1111, 32'h7654_3210);
        t_shadow(22, 4'b0110, 32'hFFFF_FFFF);
        t_shadow(22, 4'b0001, 32'h0000_00FF);
        t_shadow(23, 4'b1111, 32'hE4B1_9C27);
        t_shadow(23, 4'b1010, 32'h3300_3300);
        t_shadow(23, 4'b0000, 32'hFFFF_FFFF);
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule